// File: doc/BRIEF.md
# Network Receive Event Statistics Counters

This block keeps two 16-bit statistics for the receive side of an Ethernet MAC. The first counts frames that were dropped because no buffer space was free. The second counts receive collisions, and late collisions are included. The receive logic sends one single-cycle pulse per event. Each counter then advances by one and wraps to zero after its largest value. When a counter wraps, the block sets a sticky overflow flag in a shared status and control register. Software clears that flag by writing a 1 to it.

Software reaches the block through a small synchronous register port. The port has an address, a write strobe, 16-bit write data and combinational read data. The status register holds a halt bit. While the halt bit is set, both counters and both flags are cleared and kept at zero. The status register also holds a test-enable bit. While that bit is set, a write to a counter's address advances the counter by one, which lets a bench or a self-test reach the wrap value without real traffic.

Top module: `netstat_counters`

## Requirements
- R1: After a synchronous active-high reset, both counters read 0 and the status register reads 0, so the halt bit, the test-enable bit and both overflow flags are all clear.
- R2: Each cycle in which `miss_evt` is high advances the missed-frame counter (address 1) by one. The collision counter does not change.
- R3: Each cycle in which `coll_evt` is high advances the collision counter (address 2) by one. The missed-frame counter does not change.
- R4: `reg_rdata` shows the register selected by `reg_addr` in the same cycle. Every register can be read at any time, including while the halt bit is set.
- R5: While the halt bit (status bit 0) is set, both counters and both overflow flags are cleared and held at 0. Event pulses and test writes have no effect while it is set.
- R6: When the missed-frame counter holds 65535 and advances once more, it wraps to 0 and sets the missed-frame overflow flag at status bit 9.
- R7: When the collision counter holds 65535 and advances once more, it wraps to 0 and sets the collision overflow flag at status bit 5.
- R8: Overflow flags stay set until a status write carries a 1 in the flag's bit position. A status write with 0 in that position leaves the flag set.
- R9: While the test-enable bit (status bit 15) is set, a write to a counter's address advances that counter by one. The write data is discarded.
- R10: While the test-enable bit is clear, writes to the counter addresses leave both counters unchanged.
- R11: If an event pulse and a test write reach the same counter in the same cycle, the counter advances by two. The wrap and flag rules still hold, so 65534 plus two gives 0 and sets the flag.
- R12: Address 3 is unmapped and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_evt | input | 1 | One-cycle pulse: a frame was dropped for lack of buffer space |
| coll_evt | input | 1 | One-cycle pulse: a receive collision, regular or late |
| reg_addr | input | 2 | Register select: 0 status, 1 missed count, 2 collision count |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data of the selected register |

## Verification
The bench drives both counters all the way to 65535 and then past it. A design that saturated at the top value, or forgot to set the flag at bit 9 or bit 5, would show a wrong count or a wrong status word there. A second run uses paired event pulses and test writes to step from 65534 straight past the wrap by two. A counter that added only one per cycle in that case, or missed the carry, would fail that check. Further checks cover the flags: writing 0 to a flag bit must leave it set, clearing one flag must leave the other alone, and the halt bit must clear both. Writes made while test mode is off must leave the counters unchanged, and test writes must never load their data into a counter.

// File: rtl/netstat_pkg.sv
package netstat_pkg;

  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MISS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COLL = 2'd2;

  // status register bit positions
  localparam int BIT_HALT     = 0;
  localparam int BIT_COLL_OVF = 5;
  localparam int BIT_MISS_OVF = 9;
  localparam int BIT_TEST_EN  = 15;

  // compose the status word from its fields
  function automatic logic [DATA_W-1:0] pack_status(input logic halt,
                                                    input logic coll_ovf,
                                                    input logic miss_ovf,
                                                    input logic test_en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_HALT]     = halt;
    w[BIT_COLL_OVF] = coll_ovf;
    w[BIT_MISS_OVF] = miss_ovf;
    w[BIT_TEST_EN]  = test_en;
    return w;
  endfunction

endpackage

// File: rtl/netstat_counter.sv
module netstat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         evt,
  input  logic         tst,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  // sum of the count and a step of 0..2, with the carry in the top bit
  function automatic logic [W:0] step(input logic [W-1:0] v, input logic [1:0] n);
    return {1'b0, v} + (W+1)'(n);
  endfunction

  logic [W-1:0] cnt_q;
  logic [1:0]   inc;
  logic [W:0]   nxt;
  logic         advance;

  assign inc     = {1'b0, evt} + {1'b0, tst};
  assign nxt     = step(cnt_q, inc);
  assign advance = !clr && (inc != 2'd0);
  assign wrap_o  = advance && nxt[W];

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (advance) cnt_q <= nxt[W-1:0];
  end

  assign cnt_o = cnt_q;

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_o == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !evt && !tst) |=> $stable(cnt_o));

  // R6
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_o < W'(2)));

endmodule

// File: rtl/netstat_ctrl.sv
module netstat_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic stat_we,
  input  logic wd_halt,
  input  logic wd_test_en,
  input  logic wd_miss_clr,
  input  logic wd_coll_clr,
  input  logic miss_wrap,
  input  logic coll_wrap,
  output logic halt_o,
  output logic test_en_o,
  output logic miss_ovf_o,
  output logic coll_ovf_o
);

  logic halt_q, test_q, miss_q, coll_q;
  logic miss_w1c, coll_w1c;

  assign miss_w1c = stat_we && wd_miss_clr;
  assign coll_w1c = stat_we && wd_coll_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      test_q <= 1'b0;
    end else if (stat_we) begin
      halt_q <= wd_halt;
      test_q <= wd_test_en;
    end
  end

  // sticky flags: a new wrap wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst || halt_q) begin
      miss_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      if (miss_wrap) miss_q <= 1'b1;
      else if (miss_w1c) miss_q <= 1'b0;
      if (coll_wrap) coll_q <= 1'b1;
      else if (coll_w1c) coll_q <= 1'b0;
    end
  end

  assign halt_o     = halt_q;
  assign test_en_o  = test_q;
  assign miss_ovf_o = miss_q;
  assign coll_ovf_o = coll_q;

  // R6
  miss_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_wrap && !halt_o) |=> miss_ovf_o);

  // R7
  coll_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (coll_wrap && !halt_o) |=> coll_ovf_o);

  // R8
  miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_ovf_o && !halt_o && !miss_w1c) |=> miss_ovf_o);

  // R8
  coll_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (coll_ovf_o && !halt_o && !coll_w1c) |=> coll_ovf_o);

  // R5
  halt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> (!miss_ovf_o && !coll_ovf_o));

endmodule

// File: rtl/netstat_counters.sv
module netstat_counters
  import netstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_evt,
  input  logic              coll_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  logic halt, test_en, miss_ovf, coll_ovf;
  logic stat_we, miss_tst, coll_tst;
  logic miss_wrap, coll_wrap;
  logic [CNT_W-1:0] miss_cnt, coll_cnt;
  logic [DATA_W-1:0] wdata_unused;

  // named write decodes
  assign stat_we  = reg_we && (reg_addr == ADDR_STAT);
  assign miss_tst = reg_we && (reg_addr == ADDR_MISS) && test_en;
  assign coll_tst = reg_we && (reg_addr == ADDR_COLL) && test_en;

  // counter writes discard their data; only four status bits are stored
  assign wdata_unused = reg_wdata;

  netstat_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .stat_we     (stat_we),
    .wd_halt     (reg_wdata[BIT_HALT]),
    .wd_test_en  (reg_wdata[BIT_TEST_EN]),
    .wd_miss_clr (reg_wdata[BIT_MISS_OVF]),
    .wd_coll_clr (reg_wdata[BIT_COLL_OVF]),
    .miss_wrap   (miss_wrap),
    .coll_wrap   (coll_wrap),
    .halt_o      (halt),
    .test_en_o   (test_en),
    .miss_ovf_o  (miss_ovf),
    .coll_ovf_o  (coll_ovf)
  );

  netstat_counter #(.W(CNT_W)) u_miss (
    .clk    (clk),
    .rst    (rst),
    .clr    (halt),
    .evt    (miss_evt),
    .tst    (miss_tst),
    .cnt_o  (miss_cnt),
    .wrap_o (miss_wrap)
  );

  netstat_counter #(.W(CNT_W)) u_coll (
    .clk    (clk),
    .rst    (rst),
    .clr    (halt),
    .evt    (coll_evt),
    .tst    (coll_tst),
    .cnt_o  (coll_cnt),
    .wrap_o (coll_wrap)
  );

  always_comb begin
    case (reg_addr)
      ADDR_STAT: reg_rdata = pack_status(halt, coll_ovf, miss_ovf, test_en);
      ADDR_MISS: reg_rdata = DATA_W'(miss_cnt);
      ADDR_COLL: reg_rdata = DATA_W'(coll_cnt);
      default:   reg_rdata = '0;
    endcase
  end

  // R10
  miss_wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_MISS && !test_en && !miss_evt && !halt)
      |=> $stable(miss_cnt));

  // R10
  coll_wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_COLL && !test_en && !coll_evt && !halt)
      |=> $stable(coll_cnt));

  // R2
  miss_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (!miss_evt && !miss_tst && !halt) |=> $stable(miss_cnt));

  // R3
  coll_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (!coll_evt && !coll_tst && !halt) |=> $stable(coll_cnt));

endmodule

// File: tb/sim_netstat_counters.sv
module sim_netstat_counters;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_evt = 1'b0;
  logic        coll_evt = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  netstat_counters u0 (
    .clk       (clk),
    .rst       (rst),
    .miss_evt  (miss_evt),
    .coll_evt  (coll_evt),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // monitor: compares the read data against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (reg_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.req, reg_rdata, it.exp);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string r);
    item_t it;
    @(negedge clk);
    reg_we   = 1'b0;
    reg_addr = a;
    it.exp = e;
    it.req = r;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic pulse_miss(input int n);
    @(negedge clk);
    miss_evt = 1'b1;
    repeat (n) @(negedge clk);
    miss_evt = 1'b0;
  endtask

  task automatic pulse_coll(input int n);
    @(negedge clk);
    coll_evt = 1'b1;
    repeat (n) @(negedge clk);
    coll_evt = 1'b0;
  endtask

  // event and test write on the missed-frame counter, n cycles together
  task automatic paired_miss(input int n);
    @(negedge clk);
    reg_addr  = 2'd1;
    reg_wdata = 16'h0;
    reg_we    = 1'b1;
    miss_evt  = 1'b1;
    repeat (n) @(negedge clk);
    reg_we    = 1'b0;
    miss_evt  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 unmapped address
    expect_reg(2'd0, 16'h0000, "R1 status");
    expect_reg(2'd1, 16'h0000, "R1 miss");
    expect_reg(2'd2, 16'h0000, "R1 coll");
    expect_reg(2'd3, 16'h0000, "R12 unmapped");

    // R2 / R3 event counting, each counter isolated
    pulse_miss(3);
    expect_reg(2'd1, 16'd3, "R2 miss count");
    expect_reg(2'd2, 16'd0, "R2 coll untouched");
    pulse_coll(5);
    expect_reg(2'd2, 16'd5, "R3 coll count");
    expect_reg(2'd1, 16'd3, "R3 miss untouched");

    // R10 writes ignored with test mode off
    wr(2'd1, 16'hABCD);
    wr(2'd2, 16'h1111);
    expect_reg(2'd1, 16'd3, "R10 miss write ignored");
    expect_reg(2'd2, 16'd5, "R10 coll write ignored");

    // R9 test-write increments, data discarded
    wr(2'd0, 16'h8000);
    expect_reg(2'd0, 16'h8000, "R9 test enable readback");
    wr(2'd1, 16'h1234);
    expect_reg(2'd1, 16'd4, "R9 miss test write");
    wr(2'd2, 16'hFFFF);
    expect_reg(2'd2, 16'd6, "R9 coll test write");

    // R11 event plus test write advance by two
    paired_miss(1);
    expect_reg(2'd1, 16'd6, "R11 paired step");

    // R5 halt clears and holds, R4 reads during halt
    wr(2'd0, 16'h8001);
    expect_reg(2'd0, 16'h8001, "R4 status during halt");
    expect_reg(2'd1, 16'd0, "R5 miss cleared");
    expect_reg(2'd2, 16'd0, "R5 coll cleared");
    pulse_miss(2);
    wr(2'd2, 16'h0);
    expect_reg(2'd1, 16'd0, "R5 miss event ignored");
    expect_reg(2'd2, 16'd0, "R5 coll test write ignored");
    wr(2'd0, 16'h8000);

    // drive both to the top value
    @(negedge clk);
    miss_evt = 1'b1;
    coll_evt = 1'b1;
    repeat (65535) @(negedge clk);
    miss_evt = 1'b0;
    coll_evt = 1'b0;
    expect_reg(2'd1, 16'hFFFF, "R6 miss at top");
    expect_reg(2'd2, 16'hFFFF, "R7 coll at top");
    expect_reg(2'd0, 16'h8000, "R6 no flag before wrap");

    // R6 / R7 wrap and flags
    pulse_miss(1);
    expect_reg(2'd1, 16'd0, "R6 miss wrapped");
    expect_reg(2'd0, 16'h8200, "R6 miss flag bit 9");
    pulse_coll(1);
    expect_reg(2'd2, 16'd0, "R7 coll wrapped");
    expect_reg(2'd0, 16'h8220, "R7 coll flag bit 5");

    // R8 write-one-to-clear, zero leaves flag set
    wr(2'd0, 16'h8200);
    expect_reg(2'd0, 16'h8020, "R8 clear miss flag only");
    wr(2'd0, 16'h8000);
    expect_reg(2'd0, 16'h8020, "R8 zero write keeps flag");
    pulse_miss(1);
    expect_reg(2'd0, 16'h8020, "R8 flag still sticky");

    // R5 halt clears the flags
    wr(2'd0, 16'h8001);
    expect_reg(2'd0, 16'h8001, "R5 flags cleared by halt");
    wr(2'd0, 16'h8000);

    // R11 wrap by two from 65534
    paired_miss(32767);
    expect_reg(2'd1, 16'hFFFE, "R11 paired to 65534");
    expect_reg(2'd0, 16'h8000, "R11 no flag yet");
    paired_miss(1);
    expect_reg(2'd1, 16'd0, "R11 wrap by two");
    expect_reg(2'd0, 16'h8200, "R11 flag on paired wrap");

    repeat (3) @(negedge clk);
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule